// File: doc/BRIEF.md
# Ring-Buffer Delay Memory Address Generator

This block forms the external delay-memory address for each step of an audio effects microprogram. For every step it takes a base entry from a small table and adds three things to it: a frame offset that counts down once per sample frame, an optional modulation offset held in an internal address register, and an optional increment of one. The sum is then folded into a power-of-two ring whose size can be selected, so that delay lines wrap around on their own. In table mode the frame offset is not added and the sum simply wraps at 64K words. A bank pointer, shifted up by twelve places, is added last.

Read and write strobes to a simple synchronous RAM are issued only on odd-numbered steps. A read word is captured into a hold register. A later step that carries a write-back request copies the held word to one of the readback registers, and forwards it straight onto the input bus when that step also selects the same register. The block also maintains the modulation address register, which loads either from the shifter output or from the input bus. Packing of sample data is not part of this block. The RAM sees the upper sixteen bits of the shifter output.

Top module: `dlyaddr_gen`

## Requirements
- R1: For a step with table mode off, the 16-bit sum is base[op_sel] + frame offset + (op_mod ? modulation register zero-extended : 0) + (op_inc ? 1 : 0), taken modulo 2^16. Base entries are written through base_we/base_idx/base_data and take effect from the next cycle.
- R2: With op_table set, the frame offset is left out of the sum and the sum wraps only at 2^16. No ring mask is applied.
- R3: With table mode off, the sum is ANDed with 2^(13+ring_code)-1 before the bank is added. The ring code is loaded by ring_we and resets to 2, which gives a ring of 0x8000 words.
- R4: mem_addr equals the masked sum plus bank shifted left by 12, taken modulo 2^20. It is registered one cycle after the step.
- R5: mem_rd and mem_wr pulse in the cycle after a step only when step_idx bit 0 is 1. Steps with an even index produce no strobe. On a write strobe, mem_wdata equals sh_val[23:8] of that step.
- R6: A step with both op_rd and op_wr set, odd or even, produces no strobe. It raises err_rw for the following cycle. err_rw is low after any other step.
- R7: A step with op_adr_load loads the 12-bit modulation register. It takes sh_val[23:12] when op_shift3 is set, and otherwise in_bus[23:16] sign-extended to 12 bits. The address of that same step still uses the previous register value.
- R8: The frame offset resets to 0 and decreases by 1, modulo 2^16, on each frame_tick. A step in the same cycle as a tick uses the value from before the decrement.
- R9: mem_rdata, returned by the RAM in the cycle after mem_rd, is captured into the hold register at the end of that cycle. From then on rb_data shows {held word, 8'h00}.
- R10: During a step with op_iwt set, rb_we is 1 and rb_idx equals op_iwa. fwd_hit is 1 exactly when op_ira bit 5 is 0 and op_ira[4:0] equals op_iwa.
- R11: After reset, mem_rd, mem_wr, err_rw are 0 and the modulation register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we | input | 1 | Base table write enable |
| base_idx | input | 5 | Base table write index |
| base_data | input | 16 | Base table write data |
| ring_we | input | 1 | Ring size code load |
| ring_code | input | 2 | Ring size code, ring = 2^(13+code) words |
| bank | input | 8 | Bank pointer, added at bit 12 |
| frame_tick | input | 1 | End of sample frame, decrements offset |
| step_valid | input | 1 | A microprogram step is presented |
| step_idx | input | 7 | Step number; bit 0 gates memory access |
| op_sel | input | 5 | Base table entry select |
| op_table | input | 1 | Table mode: no offset, 64K wrap |
| op_mod | input | 1 | Add modulation register |
| op_inc | input | 1 | Add one |
| op_rd | input | 1 | Memory read request |
| op_wr | input | 1 | Memory write request |
| op_adr_load | input | 1 | Load modulation register |
| op_shift3 | input | 1 | Modulation load source is shifter |
| sh_val | input | 24 | Shifter output of this step |
| in_bus | input | 24 | Input bus value of this step |
| op_iwt | input | 1 | Write held read word back |
| op_iwa | input | 5 | Readback register index |
| op_ira | input | 6 | Input select of this step |
| mem_rdata | input | 16 | RAM read data, one cycle after mem_rd |
| mem_addr | output | 20 | RAM address |
| mem_rd | output | 1 | RAM read strobe |
| mem_wr | output | 1 | RAM write strobe |
| mem_wdata | output | 16 | RAM write data |
| rb_we | output | 1 | Readback register write |
| rb_idx | output | 5 | Readback register index |
| rb_data | output | 24 | Held read word, left-aligned |
| fwd_hit | output | 1 | Held word must replace the input bus |
| err_rw | output | 1 | Read and write were requested in one step |

## Verification
A wrong frame offset, ring code or modulation register does not show up at once. It appears on mem_addr at the first odd step that adds that term, one cycle after the step. An offset that is off by one therefore shows as an address that is off by one in every non-table access, while table-mode accesses stay correct. A fault in the hold register shows only when a later write-back step exposes rb_data, which is at least two cycles after the read strobe. A parity fault in the step gate doubles or removes strobes in the cycle right after the step.

// File: rtl/dlyaddr_pkg.sv
package dlyaddr_pkg;

   // per-step memory operation flags
   typedef struct packed {
      logic table_mode;
      logic mod_add;
      logic bump;
      logic rd;
      logic wr;
   } mem_op_t;

endpackage

// File: rtl/dlyaddr_base_tbl.sv
module dlyaddr_base_tbl #(
   parameter int DEPTH = 32,
   parameter int W     = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [W-1:0]     wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [W-1:0]     rdata
);

   logic [W-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent[i] <= '0;
         else if (we && (widx == IDX_W'(i)))
            ent[i] <= wdata;
      end
   end

   assign rdata = ent[ridx];

endmodule

// File: rtl/dlyaddr_regs.sv
module dlyaddr_regs #(
   parameter int BASE_W        = 16,
   parameter int MOD_W         = 12,
   parameter int DATA_W        = 24,
   parameter int IN_SHIFT      = 16,
   parameter int RING_CODE_W   = 2,
   parameter int RING_RST_CODE = 2,
   localparam int IN_HI_W      = DATA_W - IN_SHIFT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frame_tick,
   input  logic                   ring_we,
   input  logic [RING_CODE_W-1:0] ring_code_in,
   input  logic                   adr_load,
   input  logic                   shift3,
   input  logic [DATA_W-1:0]      sh_val,
   input  logic [DATA_W-1:0]      in_bus,
   output logic [BASE_W-1:0]      frame_off,
   output logic [MOD_W-1:0]       mod_reg,
   output logic [RING_CODE_W-1:0] ring_code
);

   if (IN_HI_W > MOD_W) begin : g_bad_in
      $error("modulation register narrower than input slice");
   end
   if (MOD_W > DATA_W) begin : g_bad_mod
      $error("modulation register wider than data path");
   end

   logic [MOD_W-1:0] in_ext;
   assign in_ext = MOD_W'($signed(in_bus[DATA_W-1 -: IN_HI_W]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_off <= '0;
         mod_reg   <= '0;
         ring_code <= RING_CODE_W'(RING_RST_CODE);
      end else begin
         if (frame_tick)
            frame_off <= frame_off - BASE_W'(1);
         if (ring_we)
            ring_code <= ring_code_in;
         if (adr_load)
            mod_reg <= shift3 ? sh_val[DATA_W-1 -: MOD_W] : in_ext;
      end
   end

   AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick |=> frame_off == $past(frame_off) - BASE_W'(1)); // R8
   AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> $stable(frame_off)); // R8
   AST_MOD_SHIFT3: assert property (@(posedge clk) disable iff (!rst_n)
      adr_load && shift3 |=> mod_reg == $past(sh_val[DATA_W-1 -: MOD_W])); // R7

endmodule

// File: rtl/dlyaddr_calc.sv
module dlyaddr_calc
   import dlyaddr_pkg::*;
#(
   parameter int BASE_W        = 16,
   parameter int MOD_W         = 12,
   parameter int RING_CODE_W   = 2,
   parameter int RING_MIN_LOG2 = 13,
   parameter int BANK_W        = 8,
   parameter int BANK_SHIFT    = 12,
   localparam int ADDR_W       = BANK_W + BANK_SHIFT
) (
   input  mem_op_t                op,
   input  logic [BASE_W-1:0]      base,
   input  logic [BASE_W-1:0]      frame_off,
   input  logic [MOD_W-1:0]       mod_reg,
   input  logic [RING_CODE_W-1:0] ring_code,
   input  logic [BANK_W-1:0]      bank,
   output logic [ADDR_W-1:0]      addr
);

   if (ADDR_W < BASE_W) begin : g_bad_addr
      $error("address narrower than ring sum");
   end
   if (MOD_W > BASE_W) begin : g_bad_mod
      $error("modulation wider than ring sum");
   end

   logic [BASE_W-1:0] sum;
   logic [BASE_W-1:0] mask;

   always_comb begin
      sum = base
          + (op.table_mode ? '0 : frame_off)
          + (op.mod_add    ? BASE_W'(mod_reg) : '0)
          + (op.bump       ? BASE_W'(1) : '0);
   end

   // ring mask, one bit per address position; table mode opens every bit
   for (genvar i = 0; i < BASE_W; i++) begin : g_mask
      if (i < RING_MIN_LOG2) begin : g_always
         assign mask[i] = 1'b1;
      end else begin : g_sized
         assign mask[i] = op.table_mode |
                          ((RING_MIN_LOG2 + int'(ring_code)) > i);
      end
   end

   assign addr = ADDR_W'(sum & mask) + (ADDR_W'(bank) << BANK_SHIFT);

endmodule

// File: rtl/dlyaddr_rdback.sv
module dlyaddr_rdback #(
   parameter int MEM_W  = 16,
   parameter int DATA_W = 24,
   parameter int RB_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_issued,
   input  logic [MEM_W-1:0]  mem_rdata,
   input  logic              step_valid,
   input  logic              iwt,
   input  logic [RB_W-1:0]   iwa,
   input  logic [RB_W:0]     ira,
   output logic              rb_we,
   output logic [RB_W-1:0]   rb_idx,
   output logic [DATA_W-1:0] rb_data,
   output logic              fwd_hit
);

   if (DATA_W < MEM_W) begin : g_bad_w
      $error("data path narrower than memory word");
   end

   logic             rd_pend;
   logic [MEM_W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         held    <= '0;
      end else begin
         rd_pend <= rd_issued;
         if (rd_pend)
            held <= mem_rdata;
      end
   end

   assign rb_we   = step_valid & iwt;
   assign rb_idx  = iwa;
   assign rb_data = {held, {(DATA_W-MEM_W){1'b0}}};
   assign fwd_hit = rb_we & ~ira[RB_W] & (ira[RB_W-1:0] == iwa);

   AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pend |=> rb_data[DATA_W-1 -: MEM_W] == $past(mem_rdata)); // R9
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_pend |=> $stable(rb_data)); // R9
   AST_FWD_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_hit |-> rb_we); // R10

endmodule

// File: rtl/dlyaddr_gen.sv
module dlyaddr_gen
   import dlyaddr_pkg::*;
#(
   parameter int TBL_DEPTH     = 32,
   parameter int BASE_W        = 16,
   parameter int MOD_W         = 12,
   parameter int DATA_W        = 24,
   parameter int MEM_W         = 16,
   parameter int IN_SHIFT      = 16,
   parameter int RING_CODE_W   = 2,
   parameter int RING_MIN_LOG2 = 13,
   parameter int RING_RST_CODE = 2,
   parameter int BANK_W        = 8,
   parameter int BANK_SHIFT    = 12,
   parameter int STEP_W        = 7,
   parameter int RB_W          = 5,
   localparam int SEL_W        = $clog2(TBL_DEPTH),
   localparam int ADDR_W       = BANK_W + BANK_SHIFT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   base_we,
   input  logic [SEL_W-1:0]       base_idx,
   input  logic [BASE_W-1:0]      base_data,
   input  logic                   ring_we,
   input  logic [RING_CODE_W-1:0] ring_code,
   input  logic [BANK_W-1:0]      bank,
   input  logic                   frame_tick,
   input  logic                   step_valid,
   input  logic [STEP_W-1:0]      step_idx,
   input  logic [SEL_W-1:0]       op_sel,
   input  logic                   op_table,
   input  logic                   op_mod,
   input  logic                   op_inc,
   input  logic                   op_rd,
   input  logic                   op_wr,
   input  logic                   op_adr_load,
   input  logic                   op_shift3,
   input  logic [DATA_W-1:0]      sh_val,
   input  logic [DATA_W-1:0]      in_bus,
   input  logic                   op_iwt,
   input  logic [RB_W-1:0]        op_iwa,
   input  logic [RB_W:0]          op_ira,
   input  logic [MEM_W-1:0]       mem_rdata,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic                   mem_rd,
   output logic                   mem_wr,
   output logic [MEM_W-1:0]       mem_wdata,
   output logic                   rb_we,
   output logic [RB_W-1:0]        rb_idx,
   output logic [DATA_W-1:0]      rb_data,
   output logic                   fwd_hit,
   output logic                   err_rw
);

   if (TBL_DEPTH != (1 << SEL_W)) begin : g_bad_depth
      $error("table depth must be a power of two");
   end
   if (STEP_W < 1) begin : g_bad_step
      $error("step index needs at least one bit");
   end

   mem_op_t                op;
   logic [BASE_W-1:0]      base_q;
   logic [BASE_W-1:0]      frame_off;
   logic [MOD_W-1:0]       mod_reg;
   logic [RING_CODE_W-1:0] ring_cur;
   logic [ADDR_W-1:0]      addr_nx;
   logic                   odd_step;
   logic                   clash;

   assign op = '{table_mode: op_table, mod_add: op_mod, bump: op_inc,
                 rd: op_rd, wr: op_wr};

   dlyaddr_base_tbl #(.DEPTH(TBL_DEPTH), .W(BASE_W)) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (base_we),
      .widx  (base_idx),
      .wdata (base_data),
      .ridx  (op_sel),
      .rdata (base_q)
   );

   dlyaddr_regs #(
      .BASE_W(BASE_W), .MOD_W(MOD_W), .DATA_W(DATA_W), .IN_SHIFT(IN_SHIFT),
      .RING_CODE_W(RING_CODE_W), .RING_RST_CODE(RING_RST_CODE)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_tick   (frame_tick),
      .ring_we      (ring_we),
      .ring_code_in (ring_code),
      .adr_load     (step_valid & op_adr_load),
      .shift3       (op_shift3),
      .sh_val       (sh_val),
      .in_bus       (in_bus),
      .frame_off    (frame_off),
      .mod_reg      (mod_reg),
      .ring_code    (ring_cur)
   );

   dlyaddr_calc #(
      .BASE_W(BASE_W), .MOD_W(MOD_W), .RING_CODE_W(RING_CODE_W),
      .RING_MIN_LOG2(RING_MIN_LOG2), .BANK_W(BANK_W), .BANK_SHIFT(BANK_SHIFT)
   ) u_calc (
      .op        (op),
      .base      (base_q),
      .frame_off (frame_off),
      .mod_reg   (mod_reg),
      .ring_code (ring_cur),
      .bank      (bank),
      .addr      (addr_nx)
   );

   dlyaddr_rdback #(.MEM_W(MEM_W), .DATA_W(DATA_W), .RB_W(RB_W)) u_rdback (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_issued  (mem_rd),
      .mem_rdata  (mem_rdata),
      .step_valid (step_valid),
      .iwt        (op_iwt),
      .iwa        (op_iwa),
      .ira        (op_ira),
      .rb_we      (rb_we),
      .rb_idx     (rb_idx),
      .rb_data    (rb_data),
      .fwd_hit    (fwd_hit)
   );

   assign odd_step = step_valid & step_idx[0];
   assign clash    = step_valid & op_rd & op_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr  <= '0;
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_wdata <= '0;
         err_rw    <= 1'b0;
      end else begin
         mem_rd <= odd_step & op_rd & ~op_wr;
         mem_wr <= odd_step & op_wr & ~op_rd;
         err_rw <= clash;
         if (odd_step && (op_rd ^ op_wr)) begin
            mem_addr  <= addr_nx;
            mem_wdata <= sh_val[DATA_W-1 -: MEM_W];
         end
      end
   end

   AST_EVEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid && !step_idx[0] |=> !mem_rd && !mem_wr); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !step_valid |=> !mem_rd && !mem_wr && !err_rw); // R5
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R6
   AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid && op_rd && op_wr |=> err_rw && !mem_rd && !mem_wr); // R6
   AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      odd_step && !op_table && (op_rd ^ op_wr) && bank == '0 && !ring_we
      |=> (mem_addr >> (RING_MIN_LOG2 + int'(ring_cur))) == '0); // R3

endmodule

// File: tb/dlyaddr_gen_test.sv
module dlyaddr_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_we = 0;
   logic [4:0]  base_idx = 0;
   logic [15:0] base_data = 0;
   logic        ring_we = 0;
   logic [1:0]  ring_code = 0;
   logic [7:0]  bank = 0;
   logic        frame_tick = 0;
   logic        step_valid = 0;
   logic [6:0]  step_idx = 0;
   logic [4:0]  op_sel = 0;
   logic        op_table = 0, op_mod = 0, op_inc = 0, op_rd = 0, op_wr = 0;
   logic        op_adr_load = 0, op_shift3 = 0;
   logic [23:0] sh_val = 0, in_bus = 0;
   logic        op_iwt = 0;
   logic [4:0]  op_iwa = 0;
   logic [5:0]  op_ira = 0;
   logic [15:0] mem_rdata = 0;
   logic [19:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_wdata;
   logic        rb_we;
   logic [4:0]  rb_idx;
   logic [23:0] rb_data;
   logic        fwd_hit, err_rw;

   int total = 0;
   int bad   = 0;
   logic finished = 0;

   // bench-side model state
   logic [15:0] base_m [32];
   logic [15:0] off_m = 0;
   logic [11:0] mod_m = 0;
   int          code_m = 2;

   always #2.5 clk = ~clk;

   dlyaddr_gen uut (
      .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_idx(base_idx),
      .base_data(base_data), .ring_we(ring_we), .ring_code(ring_code),
      .bank(bank), .frame_tick(frame_tick), .step_valid(step_valid),
      .step_idx(step_idx), .op_sel(op_sel), .op_table(op_table),
      .op_mod(op_mod), .op_inc(op_inc), .op_rd(op_rd), .op_wr(op_wr),
      .op_adr_load(op_adr_load), .op_shift3(op_shift3), .sh_val(sh_val),
      .in_bus(in_bus), .op_iwt(op_iwt), .op_iwa(op_iwa), .op_ira(op_ira),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .rb_we(rb_we), .rb_idx(rb_idx),
      .rb_data(rb_data), .fwd_hit(fwd_hit), .err_rw(err_rw)
   );

   // RAM stand-in: read word is a fixed function of the address
   always @(posedge clk)
      if (mem_rd) mem_rdata <= mem_addr[15:0] ^ 16'hA5C3;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [19:0] exp_addr(input logic [4:0] sel, input logic tbl,
                                            input logic md, input logic inc,
                                            input logic [7:0] bk);
      logic [15:0] s;
      logic [15:0] m;
      s = base_m[sel] + (tbl ? 16'd0 : off_m) + (md ? {4'd0, mod_m} : 16'd0)
          + (inc ? 16'd1 : 16'd0);
      m = tbl ? s : (s & 16'((32'd1 << (13 + code_m)) - 1));
      return 20'({4'd0, m}) + 20'({bk, 12'd0});
   endfunction

   task automatic clear_step();
      step_valid = 0; op_rd = 0; op_wr = 0; op_adr_load = 0; op_iwt = 0;
      frame_tick = 0; op_table = 0; op_mod = 0; op_inc = 0;
   endtask

   task automatic load_base(input int i, input logic [15:0] v);
      base_we = 1; base_idx = 5'(i); base_data = v;
      @(posedge clk); @(negedge clk);
      base_we = 0;
      base_m[i] = v;
   endtask

   task automatic set_ring(input int c);
      ring_we = 1; ring_code = 2'(c);
      @(posedge clk); @(negedge clk);
      ring_we = 0;
      code_m = c;
   endtask

   initial begin
      int guard = 0;
      while (!finished && guard < 100000) begin
         @(posedge clk);
         guard++;
      end
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=running exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [19:0] ea;
      logic        er, ew;
      for (int i = 0; i < 32; i++) base_m[i] = 16'd0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 rd", {31'd0, mem_rd}, 0);
      chk("R11 wr", {31'd0, mem_wr}, 0);
      chk("R11 err", {31'd0, err_rw}, 0);
      rst_n = 1;
      @(negedge clk);

      // R3 ring resets to 0x8000: full-scale base folds to 0x7FFF
      load_base(0, 16'hFFFF);
      step_valid = 1; step_idx = 7'd1; op_sel = 0; op_rd = 1;
      @(posedge clk); @(negedge clk);
      chk("R3 reset ring", {12'd0, mem_addr}, 32'h7FFF);
      clear_step();
      // R11 modulation register zero after reset
      op_mod = 1; step_valid = 1; op_rd = 1; op_table = 1;
      @(posedge clk); @(negedge clk);
      chk("R11 modreg", {12'd0, mem_addr}, 32'hFFFF);
      clear_step();

      for (int i = 0; i < 32; i++)
         load_base(i, 16'((i * 32'h1357 + 32'h0F1) & 32'hFFFF));

      // R1 R2 R3 R4 R5 R7 R8 sweep
      for (int i = 0; i < 160; i++) begin
         logic even;
         logic [23:0] sv, ib;
         if (i % 32 == 0) set_ring((i / 32) % 4);
         even = (i % 7 == 3);
         sv = 24'((i * 32'h2A5B3) & 32'hFFFFFF);
         ib = 24'((i * 32'h51F7D + 32'h800000) & 32'hFFFFFF);
         step_valid = 1;
         step_idx = 7'(even ? 2 * i : 2 * i + 1);
         op_sel = 5'(i % 32);
         op_table = (i % 4 == 1);
         op_mod = ((i / 2) % 2 == 1);
         op_inc = (i % 5 == 2);
         op_rd = (i % 3 != 1);
         op_wr = (i % 3 == 1);
         op_adr_load = (i % 5 == 0);
         op_shift3 = ((i / 5) % 2 == 1);
         sh_val = sv; in_bus = ib;
         bank = 8'((i * 37) & 8'hFF);
         frame_tick = (i % 3 == 0);
         ea = exp_addr(op_sel, op_table, op_mod, op_inc, bank);
         er = !even && op_rd;
         ew = !even && op_wr;
         @(posedge clk); @(negedge clk);
         chk("R5 rd strobe", {31'd0, mem_rd}, {31'd0, er});
         chk("R5 wr strobe", {31'd0, mem_wr}, {31'd0, ew});
         if (!even) chk("R1 R2 R3 R4 address", {12'd0, mem_addr}, {12'd0, ea});
         if (ew) chk("R5 wdata", {16'd0, mem_wdata}, {16'd0, sv[23:8]});
         chk("R6 no err", {31'd0, err_rw}, 0);
         // model update after the step (R7 R8)
         if (op_adr_load)
            mod_m = op_shift3 ? sv[23:12] : {{4{ib[23]}}, ib[23:16]};
         if (frame_tick) off_m = off_m - 16'd1;
         clear_step();
      end

      // R8 offset wrap below zero: compare offset through a table-off step
      set_ring(3);
      bank = 0;
      step_valid = 1; step_idx = 7'd5; op_sel = 5'd3; op_rd = 1;
      ea = exp_addr(5'd3, 0, 0, 0, 8'd0);
      @(posedge clk); @(negedge clk);
      chk("R8 offset", {12'd0, mem_addr}, {12'd0, ea});
      clear_step();

      // R6 read and write together, odd and even
      for (int k = 0; k < 2; k++) begin
         step_valid = 1; step_idx = 7'(k + 8); op_rd = 1; op_wr = 1;
         @(posedge clk); @(negedge clk);
         chk("R6 err", {31'd0, err_rw}, 1);
         chk("R6 no rd", {31'd0, mem_rd}, 0);
         chk("R6 no wr", {31'd0, mem_wr}, 0);
         clear_step();
         @(posedge clk); @(negedge clk);
         chk("R6 err clears", {31'd0, err_rw}, 0);
      end

      // R9 R10 capture and write-back with forwarding
      for (int k = 0; k < 4; k++) begin
         logic [4:0] sel;
         sel = 5'(k * 7 + 1);
         step_valid = 1; step_idx = 7'(2 * k + 1); op_sel = sel; op_rd = 1;
         op_table = 1; bank = 8'(k);
         ea = exp_addr(sel, 1, 0, 0, 8'(k));
         @(posedge clk); @(negedge clk);
         clear_step();
         @(posedge clk); @(negedge clk);
         @(posedge clk); @(negedge clk);
         step_valid = 1; op_iwt = 1; op_iwa = 5'(k + 4);
         op_ira = (k % 2 == 0) ? 6'(k + 4) : 6'(k + 4 + 32);
         #1;
         chk("R10 rb_we", {31'd0, rb_we}, 1);
         chk("R10 rb_idx", {27'd0, rb_idx}, 32'(k + 4));
         chk("R9 rb_data", {8'd0, rb_data}, {8'd0, ea[15:0] ^ 16'hA5C3, 8'h00});
         chk("R10 fwd_hit", {31'd0, fwd_hit}, (k % 2 == 0) ? 1 : 0);
         @(negedge clk);
         clear_step();
         #1;
         chk("R10 idle rb_we", {31'd0, rb_we}, 0);
         @(negedge clk);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule